// File: doc/BRIEF.md
# Coarse region snoop-avoidance filter

Each node of a snooping multiprocessor carries one copy of this filter. It works on memory regions. A region is an aligned, power-of-two sized block of the address space, and every port takes a region number: the address with its offset bits already removed.

The filter has two parts:

- **Non-shared table.** This small set-associative table records regions that the node has learned no other node caches. The node learns this when a broadcast request comes back as a global region miss. A later local request to such a region may be issued without snooping the other nodes. Any snoop from another node that names a recorded region removes that record.
- **Hashed counter array.** The node counts its locally cached blocks per hashed region index. A counter goes up on each block allocation and down on each eviction. A remote snoop whose counter reads zero is answered with "region miss", and the node can skip its own tag lookup.

Both answers are combinational, so they are given in the same cycle as the query. Table and counter updates become visible from the next cycle.

Top module: `region_snoop_filter`

## Requirements
- R1: Region numbers are RTAG_W bits wide. The table set is the low SET_LG bits of the region number, and the remaining bits form the stored tag. The counter index is region bits [HASH_LG-1:0] XOR bits [2*HASH_LG-1:HASH_LG].
- R2: `lreq_local_only` is high in the same cycle exactly when all three hold:
  - `lreq_valid` is high;
  - the region of `lreq_region` is recorded in the table;
  - no snoop in that cycle names the same region.
- R3: A cycle with `resp_valid` and `resp_global_miss` both high records `resp_region`, and a lookup of that region hits from the next cycle on. If the region is already recorded, no second copy is made and the entry only becomes most recently used. With `resp_global_miss` low, nothing is recorded.
- R4: A cycle with `snp_valid` high removes any record of `snp_region` from the next cycle on. This takes precedence over a recording of the same region in the same cycle, which is then dropped.
- R5: A new region takes the lowest-numbered invalid way of its set, or else the least recently used way. Two events make a way most recently used: an allocation into it, and a lookup that asserts `lreq_local_only`. In a cycle that allocates, the lookup does not change recency.
- R6: `alloc_valid` adds one to the counter of `alloc_region`, and `evict_valid` subtracts one from the counter of `evict_region`. When both are high and index the same counter, the count does not change. An eviction that would take a counter below zero is a protocol error and is flagged by an assertion.
- R7: `snp_region_miss` is high in the same cycle exactly when `snp_valid` is high and the counter indexed by `snp_region` is zero. Two regions that alias to one counter give a false "may be cached" and never a false miss.
- R8: After reset the table holds no region and every counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lreq_valid | input | 1 | A local coherent request is being issued |
| lreq_region | input | RTAG_W | Region number of the local request |
| lreq_local_only | output | 1 | The request may skip the broadcast |
| resp_valid | input | 1 | The combined response of a broadcast request is present |
| resp_region | input | RTAG_W | Region number of that broadcast request |
| resp_global_miss | input | 1 | No remote node holds any block of the region |
| snp_valid | input | 1 | A snoop from another node arrives |
| snp_region | input | RTAG_W | Region number of the snoop |
| snp_region_miss | output | 1 | This node holds no block in the snooped region |
| alloc_valid | input | 1 | A block is allocated in the local cache |
| alloc_region | input | RTAG_W | Region number of the allocated block |
| evict_valid | input | 1 | A block leaves the local cache |
| evict_region | input | RTAG_W | Region number of the evicted block |

## Verification
The two outputs are combinational on the current inputs and the stored state, so each is due within the cycle of its query. The bench samples them 5 ns after it drives the inputs, well before the next rising edge. Every recording, removal, recency change and counter step lands on the rising edge that ends the cycle. The bench's behavioural model applies these changes 1 ns after that edge, so the comparison in the following cycle already sees them. Both outputs are compared on every cycle after reset.

// File: rtl/region_snoop_filter.sv
`timescale 1ns/1ps
module region_snoop_filter #(
  parameter int RTAG_W  = 20,
  parameter int SET_LG  = 4,
  parameter int WAYS    = 4,
  parameter int HASH_LG = 8,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lreq_valid,
  input  logic [RTAG_W-1:0] lreq_region,
  output logic              lreq_local_only,
  input  logic              resp_valid,
  input  logic [RTAG_W-1:0] resp_region,
  input  logic              resp_global_miss,
  input  logic              snp_valid,
  input  logic [RTAG_W-1:0] snp_region,
  output logic              snp_region_miss,
  input  logic              alloc_valid,
  input  logic [RTAG_W-1:0] alloc_region,
  input  logic              evict_valid,
  input  logic [RTAG_W-1:0] evict_region
);
  localparam int SETS   = 1 << SET_LG;
  localparam int TAG_W  = RTAG_W - SET_LG;
  localparam int WAY_LG = $clog2(WAYS);
  localparam int HASH_N = 1 << HASH_LG;

  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic              valid_q [SETS][WAYS];
  logic [WAY_LG-1:0] age_q   [SETS][WAYS];
  logic [CNT_W-1:0]  cnt_q   [HASH_N];

  function automatic logic [HASH_LG-1:0] hidx(input logic [RTAG_W-1:0] r);
    return r[HASH_LG-1:0] ^ r[2*HASH_LG-1:HASH_LG];
  endfunction

  wire [SET_LG-1:0] l_set = lreq_region[SET_LG-1:0];
  wire [TAG_W-1:0]  l_tag = lreq_region[RTAG_W-1:SET_LG];
  wire [SET_LG-1:0] r_set = resp_region[SET_LG-1:0];
  wire [TAG_W-1:0]  r_tag = resp_region[RTAG_W-1:SET_LG];
  wire [SET_LG-1:0] s_set = snp_region[SET_LG-1:0];
  wire [TAG_W-1:0]  s_tag = snp_region[RTAG_W-1:SET_LG];

  wire [HASH_LG-1:0] a_idx = hidx(alloc_region);
  wire [HASH_LG-1:0] e_idx = hidx(evict_region);
  wire               same_ae = alloc_valid && evict_valid && (a_idx == e_idx);

  logic              l_hit, r_hit, r_inv;
  logic [WAY_LG-1:0] l_way, r_way, r_free, r_lru, r_vic;

  always_comb begin
    l_hit = 1'b0; l_way = '0;
    r_hit = 1'b0; r_way = '0;
    r_inv = 1'b0; r_free = '0; r_lru = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (valid_q[l_set][w] && tag_q[l_set][w] == l_tag) begin l_hit = 1'b1; l_way = WAY_LG'(w); end
      if (valid_q[r_set][w] && tag_q[r_set][w] == r_tag) begin r_hit = 1'b1; r_way = WAY_LG'(w); end
      if (!valid_q[r_set][w]) begin r_inv = 1'b1; r_free = WAY_LG'(w); end
      if (age_q[r_set][w] == WAY_LG'(WAYS - 1)) r_lru = WAY_LG'(w);
    end
    r_vic = r_hit ? r_way : (r_inv ? r_free : r_lru);
  end

  wire same_lr  = snp_valid && (snp_region == lreq_region);
  wire same_rs  = snp_valid && (snp_region == resp_region);
  wire do_alloc = resp_valid && resp_global_miss && !same_rs;

  assign lreq_local_only = lreq_valid && l_hit && !same_lr;
  assign snp_region_miss = snp_valid && (cnt_q[hidx(snp_region)] == '0);

  wire               touch = do_alloc || lreq_local_only;
  wire [SET_LG-1:0]  t_set = do_alloc ? r_set : l_set;
  wire [WAY_LG-1:0]  t_way = do_alloc ? r_vic : l_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          tag_q[s][w]   <= '0;
          age_q[s][w]   <= WAY_LG'(w);
        end
      for (int i = 0; i < HASH_N; i++) cnt_q[i] <= '0;
    end else begin
      if (snp_valid)
        for (int w = 0; w < WAYS; w++)
          if (valid_q[s_set][w] && tag_q[s_set][w] == s_tag) valid_q[s_set][w] <= 1'b0;
      if (do_alloc) begin
        valid_q[r_set][r_vic] <= 1'b1;
        tag_q[r_set][r_vic]   <= r_tag;
      end
      if (touch) begin
        for (int w = 0; w < WAYS; w++)
          if (age_q[t_set][w] < age_q[t_set][t_way]) age_q[t_set][w] <= age_q[t_set][w] + 1'b1;
        age_q[t_set][t_way] <= '0;
      end
      if (alloc_valid && !same_ae) cnt_q[a_idx] <= cnt_q[a_idx] + 1'b1;
      if (evict_valid && !same_ae) cnt_q[e_idx] <= cnt_q[e_idx] - 1'b1;
    end
  end
endmodule

// File: rtl/region_snoop_filter_chk.sv
`timescale 1ns/1ps
module region_snoop_filter_chk #(
  parameter int RTAG_W  = 20,
  parameter int SET_LG  = 4,
  parameter int WAYS    = 4,
  parameter int HASH_LG = 8,
  parameter int CNT_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lreq_valid,
  input logic              lreq_local_only,
  input logic              resp_valid,
  input logic [RTAG_W-1:0] resp_region,
  input logic              resp_global_miss,
  input logic              snp_valid,
  input logic [RTAG_W-1:0] snp_region,
  input logic              snp_region_miss,
  input logic              alloc_valid,
  input logic [RTAG_W-1:0] alloc_region,
  input logic              evict_valid,
  input logic [RTAG_W-1:0] evict_region,
  input logic [RTAG_W-SET_LG-1:0] tag_q [1<<SET_LG][WAYS],
  input logic              valid_q [1<<SET_LG][WAYS],
  input logic [CNT_W-1:0]  cnt_q [1<<HASH_LG]
);
  function automatic logic [HASH_LG-1:0] hx(input logic [RTAG_W-1:0] r);
    return r[HASH_LG-1:0] ^ r[2*HASH_LG-1:HASH_LG];
  endfunction

  logic [RTAG_W-1:0]  resp_d, snp_d;
  logic [HASH_LG-1:0] aidx_d;
  always_ff @(posedge clk) begin
    resp_d <= resp_region;
    snp_d  <= snp_region;
    aidx_d <= hx(alloc_region);
  end

  logic resp_in, snp_in;
  always_comb begin
    resp_in = 1'b0; snp_in = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_q[resp_d[SET_LG-1:0]][w] && tag_q[resp_d[SET_LG-1:0]][w] == resp_d[RTAG_W-1:SET_LG]) resp_in = 1'b1;
      if (valid_q[snp_d[SET_LG-1:0]][w] && tag_q[snp_d[SET_LG-1:0]][w] == snp_d[RTAG_W-1:SET_LG]) snp_in = 1'b1;
    end
  end

  p_local_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_local_only |-> lreq_valid);
  p_record_after_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_global_miss && !(snp_valid && snp_region == resp_region)) |=> resp_in);
  p_snoop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> !snp_in);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && !(alloc_valid && hx(alloc_region) == hx(evict_region))) |-> cnt_q[hx(evict_region)] != '0);
  p_alloc_sets_presence_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !evict_valid) |=> cnt_q[aidx_d] != '0);
  p_miss_needs_snoop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_region_miss |-> snp_valid);
endmodule

bind region_snoop_filter region_snoop_filter_chk #(
  .RTAG_W(RTAG_W), .SET_LG(SET_LG), .WAYS(WAYS), .HASH_LG(HASH_LG), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/tb_region_snoop_filter.sv
`timescale 1ns/1ps
module tb_region_snoop_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        lreq_valid = 0, resp_valid = 0, resp_global_miss = 0, snp_valid = 0;
  logic        alloc_valid = 0, evict_valid = 0;
  logic [19:0] lreq_region = 0, resp_region = 0, snp_region = 0, alloc_region = 0, evict_region = 0;
  logic        lreq_local_only, snp_region_miss;

  region_snoop_filter dut (.*);

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R8";
  bit    m_v [16][4];
  int    m_t [16][4];
  int    rec [16][$];
  int    m_cnt [256];

  function automatic int hsh(int r); return (r & 255) ^ ((r >> 8) & 255); endfunction
  function automatic int rg(int up, int s); return (up << 4) | s; endfunction
  function automatic int find(int r);
    for (int w = 0; w < 4; w++) if (m_v[r & 15][w] && m_t[r & 15][w] == r) return w;
    return -1;
  endfunction

  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic touch(int s, int w);
    foreach (rec[s][i]) if (rec[s][i] == w) begin rec[s].delete(i); break; end
    rec[s].push_front(w);
  endtask

  task automatic model_update();
    int lw, vic, s;
    bit loc, doal;
    lw   = lreq_valid ? find(lreq_region) : -1;
    loc  = lw >= 0 && !(snp_valid && snp_region == lreq_region);
    doal = resp_valid && resp_global_miss && !(snp_valid && snp_region == resp_region);
    vic  = -1;
    s    = resp_region & 15;
    if (doal) begin
      vic = find(resp_region);
      if (vic < 0) for (int w = 3; w >= 0; w--) if (!m_v[s][w]) vic = w;
      if (vic < 0) vic = rec[s][$];
    end
    if (!(alloc_valid && evict_valid && hsh(alloc_region) == hsh(evict_region))) begin
      if (alloc_valid) m_cnt[hsh(alloc_region)]++;
      if (evict_valid) m_cnt[hsh(evict_region)]--;
    end
    if (snp_valid && find(snp_region) >= 0) m_v[snp_region & 15][find(snp_region)] = 0;
    if (doal) begin
      m_v[s][vic] = 1; m_t[s][vic] = resp_region; touch(s, vic);
    end else if (loc) touch(lreq_region & 15, lw);
  endtask

  task automatic tick();
    int lw;
    #5;
    lw = lreq_valid ? find(lreq_region) : -1;
    check("lreq_local_only", lreq_local_only,
          int'(lw >= 0 && !(snp_valid && snp_region == lreq_region)));
    check("snp_region_miss", snp_region_miss, int'(snp_valid && m_cnt[hsh(snp_region)] == 0));
    @(posedge clk); #1;
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    lreq_valid = 0; resp_valid = 0; resp_global_miss = 0; snp_valid = 0;
    alloc_valid = 0; evict_valid = 0;
  endtask

  task automatic look(int r); lreq_valid = 1; lreq_region = 20'(r); endtask
  task automatic snoop(int r); snp_valid = 1; snp_region = 20'(r); endtask
  task automatic respond(int r, bit gm);
    resp_valid = 1; resp_region = 20'(r); resp_global_miss = gm;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      rec[s] = {0, 1, 2, 3};
      for (int w = 0; w < 4; w++) begin m_v[s][w] = 0; m_t[s][w] = 0; end
    end
    for (int i = 0; i < 256; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    cur_req = "R8"; look(rg(7, 3)); snoop(rg(7, 3)); tick(); idle();
    snoop(rg(255, 15)); tick(); idle();

    cur_req = "R6"; alloc_valid = 1; alloc_region = 20'(rg(2, 5)); tick(); idle();
    cur_req = "R7"; snoop(rg(2, 5)); tick(); idle();
    cur_req = "R6"; alloc_valid = 1; alloc_region = 20'(rg(2, 5));
    evict_valid = 1; evict_region = 20'(rg(2, 5)); tick(); idle();
    evict_valid = 1; evict_region = 20'(rg(2, 5)); snoop(rg(2, 5)); tick(); idle();
    cur_req = "R7"; snoop(rg(2, 5)); tick(); idle();
    alloc_valid = 1; alloc_region = 20'h00003; tick(); idle();
    snoop(20'h00102); tick(); idle();
    evict_valid = 1; evict_region = 20'h00003; tick(); idle();
    snoop(20'h00102); tick(); idle();

    cur_req = "R3"; respond(rg(9, 2), 1); tick(); idle();
    cur_req = "R2"; look(rg(9, 2)); tick(); idle();
    cur_req = "R3"; respond(rg(10, 2), 0); tick(); idle();
    look(rg(10, 2)); tick(); idle();
    cur_req = "R1"; look(rg(9, 3)); tick(); idle();
    look(rg(9 + 16, 2)); tick(); idle();
    cur_req = "R2"; look(rg(9, 2)); snoop(rg(9, 2)); tick(); idle();
    cur_req = "R4"; look(rg(9, 2)); tick(); idle();
    respond(rg(11, 2), 1); snoop(rg(11, 2)); tick(); idle();
    look(rg(11, 2)); tick(); idle();

    cur_req = "R5";
    for (int k = 1; k <= 4; k++) begin respond(rg(k, 0), 1); tick(); idle(); end
    respond(rg(1, 0), 1); tick(); idle();
    look(rg(2, 0)); tick(); idle();
    respond(rg(5, 0), 1); look(rg(4, 0)); tick(); idle();
    for (int k = 1; k <= 5; k++) begin look(rg(k, 0)); tick(); idle(); end

    cur_req = "R2 R3 R4 R5 R7 random";
    for (int c = 0; c < 4000; c++) begin
      int ar, er;
      lreq_valid = ($urandom_range(0, 1) == 1);
      lreq_region = 20'(rg($urandom_range(0, 5), $urandom_range(0, 3)));
      snp_valid = ($urandom_range(0, 9) < 3);
      snp_region = 20'(rg($urandom_range(0, 5), $urandom_range(0, 3)));
      resp_valid = ($urandom_range(0, 9) < 3);
      resp_global_miss = ($urandom_range(0, 9) < 7);
      resp_region = 20'(rg($urandom_range(0, 5), $urandom_range(0, 3)));
      ar = rg($urandom_range(0, 5), $urandom_range(0, 3));
      er = rg($urandom_range(0, 5), $urandom_range(0, 3));
      alloc_valid = ($urandom_range(0, 9) < 4) && m_cnt[hsh(ar)] < 200;
      alloc_region = 20'(ar);
      evict_valid = ($urandom_range(0, 9) < 4) && m_cnt[hsh(er)] > 0;
      evict_region = 20'(er);
      tick();
    end
    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule